// File: doc/BRIEF.md
# Guarded Compare Predicate Unit

This block executes one compare-and-set-predicate operation per clock. Two 32-bit data words are compared under a selectable condition, signed or unsigned. The single result then drives up to two one-bit predicate registers held in a small predicate file. Each destination has its own action code. The action code, the compare result and a guarding predicate read from the same file together decide whether that destination is written, and with what value.

Unconditional actions always write: the result or its inverse when the guard is set, and 0 when it is clear. The OR-style and AND-style actions write only one fixed value, and only for one combination of guard and result. A chain of such operations can therefore accumulate a wired-OR into a predicate preset to 0, or a wired-AND into a predicate preset to 1. A combinational read port lets predicated instructions fetch their guard. Entry 0 always reads as true, so an operation guarded by entry 0 always executes.

Top module: `cmp_pred_unit`

## Requirements
- R1: After reset, every predicate entry reads 0 except entry 0, which reads 1.
- R2: Entry 0 always reads 1. Any write aimed at it is ignored.
- R3: The 3-bit condition code selects EQ=0, NE=1, LT=2, LE=3, GT=4, GE=5 as signed compares of a against b, and LTU=6, GEU=7 as unsigned compares.
- R4: Action UN (code 0) writes the compare result when the guard is 1. Action UC (code 1) writes the inverted result when the guard is 1. Both write 0 when the guard is 0.
- R5: Action ON (code 2) writes 1 only when the guard is 1 and the result is 1. Action OC (code 3) writes 1 only when the guard is 1 and the result is 0. In all other cases the destination is unchanged.
- R6: Action AN (code 4) writes 0 only when the guard is 1 and the result is 0. Action AC (code 5) writes 0 only when the guard is 1 and the result is 1. In all other cases the destination is unchanged.
- R7: Action codes 6 and 7 never write.
- R8: No entry changes in a cycle without issue valid.
- R9: The guard is read from the file as it stands before the update. The update becomes visible on the read port after the next rising clock edge.
- R10: When both destinations name the same entry, the write from destination 2 wins.
- R11: A run of ON/OC operations into an entry preset to 0 leaves the OR of their terms. A run of AN/AC operations into an entry preset to 1 leaves the AND of their terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | An operation is issued this cycle |
| src_a | input | 32 | First data operand |
| src_b | input | 32 | Second data operand |
| cond | input | 3 | Compare condition code |
| guard_idx | input | 4 | Index of the guarding predicate |
| dst1_idx | input | 4 | Index of destination 1 |
| dst2_idx | input | 4 | Index of destination 2 |
| act1 | input | 3 | Action code for destination 1 |
| act2 | input | 3 | Action code for destination 2 |
| rd_idx | input | 4 | Read port index |
| rd_val | output | 1 | Predicate value at rd_idx |

## Verification
The embedded properties assume the inputs are known, 2-state values whenever issue valid is high, and that the file is only ever changed through an issued operation. The bench drives every input from a single negative-edge driver and keeps all indices inside the 16-entry range. It leaves the read index to the monitor, which sweeps it between edges, so no read overlaps an update. Operations mixing action types are issued deliberately, so the monotonic properties for the OR-only and AND-only cases see both matching and non-matching traffic.

// File: rtl/cmp_pred_unit.sv
module cmp_pred_unit #(
  parameter int DW    = 32,
  parameter int NPRED = 16,
  localparam int IW   = $clog2(NPRED)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_vld,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic [2:0]    cond,
  input  logic [IW-1:0] guard_idx,
  input  logic [IW-1:0] dst1_idx,
  input  logic [IW-1:0] dst2_idx,
  input  logic [2:0]    act1,
  input  logic [2:0]    act2,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_val
);

  logic [NPRED-1:1] pf_q;
  logic [NPRED-1:0] pf, pf_nxt;
  logic             res, guard;
  logic [1:0]       w1, w2;

  assign pf     = {pf_q, 1'b1};
  assign guard  = pf[guard_idx];
  assign rd_val = pf[rd_idx];

  always_comb begin
    case (cond)
      3'd0:    res = (src_a == src_b);
      3'd1:    res = (src_a != src_b);
      3'd2:    res = ($signed(src_a) <  $signed(src_b));
      3'd3:    res = ($signed(src_a) <= $signed(src_b));
      3'd4:    res = ($signed(src_a) >  $signed(src_b));
      3'd5:    res = ($signed(src_a) >= $signed(src_b));
      3'd6:    res = (src_a <  src_b);
      default: res = (src_a >= src_b);
    endcase
  end

  // returns {write enable, write value}
  function automatic logic [1:0] act_fn(input logic [2:0] a, input logic g, input logic r);
    case (a)
      3'd0:    act_fn = {1'b1, g & r};
      3'd1:    act_fn = {1'b1, g & ~r};
      3'd2:    act_fn = {g & r,  1'b1};
      3'd3:    act_fn = {g & ~r, 1'b1};
      3'd4:    act_fn = {g & ~r, 1'b0};
      3'd5:    act_fn = {g & r,  1'b0};
      default: act_fn = 2'b00;
    endcase
  endfunction

  assign w1 = act_fn(act1, guard, res);
  assign w2 = act_fn(act2, guard, res);

  always_comb begin
    pf_nxt = pf;
    if (issue_vld) begin
      if (w1[1]) pf_nxt[dst1_idx] = w1[0];
      if (w2[1]) pf_nxt[dst2_idx] = w2[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pf_q <= '0;
    else        pf_q <= pf_nxt[NPRED-1:1];
  end

  // R2
  entry0_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == '0) |-> rd_val);

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_vld |=> $stable(pf_q));

  // R5
  or_only_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && act1 inside {3'd2, 3'd3} && act2 inside {3'd2, 3'd3})
      |=> (($past(pf_q) & ~pf_q) == '0));

  // R6
  and_only_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && act1 inside {3'd4, 3'd5} && act2 inside {3'd4, 3'd5})
      |=> ((~$past(pf_q) & pf_q) == '0));

  // R4
  uncond_guard_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && !pf[guard_idx] && act2 inside {3'd0, 3'd1} && dst2_idx != '0)
      |=> !pf[$past(dst2_idx)]);

  // R7
  reserved_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && act1[2:1] == 2'b11 && act2[2:1] == 2'b11) |=> $stable(pf_q));

endmodule

// File: tb/cmp_pred_unit_bench.sv
`timescale 1ns/1ps
module cmp_pred_unit_bench;
  logic        clk = 0, rst_n = 0, issue_vld = 0;
  logic [31:0] src_a = 0, src_b = 0;
  logic [2:0]  cond = 0, act1 = 7, act2 = 7;
  logic [3:0]  guard_idx = 0, dst1_idx = 0, dst2_idx = 0, rd_idx = 0;
  logic        rd_val;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] model = 16'h0001;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  cmp_pred_unit u_cmp_pred_unit (.*);

  function automatic logic cmpf(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    logic signed [32:0] sa = {a[31], a};
    logic signed [32:0] sb = {b[31], b};
    logic        [32:0] ua = {1'b0, a};
    logic        [32:0] ub = {1'b0, b};
    case (c)
      0: return ua == ub;
      1: return ua != ub;
      2: return sa < sb;
      3: return !(sb < sa);
      4: return sb < sa;
      5: return !(sa < sb);
      6: return ua < ub;
      default: return !(ua < ub);
    endcase
  endfunction

  function automatic logic [15:0] apply(input logic [15:0] m, input logic [3:0] d,
                                        input logic [2:0] a, input logic g, input logic r);
    logic [15:0] o = m;
    if (a == 0) o[d] = g && r;
    else if (a == 1) o[d] = g && !r;
    else if (a == 2 && g && r) o[d] = 1'b1;
    else if (a == 3 && g && !r) o[d] = 1'b1;
    else if (a == 4 && g && !r) o[d] = 1'b0;
    else if (a == 5 && g && r) o[d] = 1'b0;
    o[0] = 1'b1;
    return o;
  endfunction

  task automatic op(input logic [3:0] g, input logic [3:0] d1, input logic [3:0] d2,
                    input logic [2:0] a1, input logic [2:0] a2, input logic [2:0] c,
                    input logic [31:0] a, input logic [31:0] b, input string tag);
    logic r, gv;
    @(negedge clk);
    issue_vld = 1; guard_idx = g; dst1_idx = d1; dst2_idx = d2;
    act1 = a1; act2 = a2; cond = c; src_a = a; src_b = b;
    r = cmpf(c, a, b); gv = model[g];
    model = apply(model, d1, a1, gv, r);
    model = apply(model, d2, a2, gv, r);
    exp_q.push_back(model); tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    issue_vld = 0; act1 = 2; act2 = 0; guard_idx = 0; dst1_idx = 3; dst2_idx = 5;
    exp_q.push_back(model); tag_q.push_back(tag);
  endtask

  task automatic sweep(output logic [15:0] img);
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i); #0.05; img[i] = rd_val;
    end
  endtask

  task automatic check_img(input logic [15:0] exp, input string tag);
    logic [15:0] got;
    sweep(got);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: compares the file image after each driven cycle
  initial forever begin
    @(posedge clk); #0.2;
    if (exp_q.size() > 0) check_img(exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #0.2 check_img(16'h0001, "R1 reset");
    // R3 conditions, R4 unconditional with guard on
    op(0, 1, 2, 0, 1, 0, 5, 5, "R3 R4 EQ UN/UC");
    op(0, 3, 4, 0, 1, 2, 32'hFFFF_FFFF, 1, "R3 LT signed");
    op(0, 5, 6, 0, 1, 6, 32'hFFFF_FFFF, 1, "R3 LTU unsigned");
    op(0, 7, 8, 0, 0, 3, 7, 7, "R3 LE equal");
    op(0, 9, 10, 0, 0, 4, 32'h8000_0000, 3, "R3 GT negative");
    op(0, 11, 12, 0, 0, 5, 3, 32'h8000_0000, "R3 GE");
    op(0, 13, 14, 0, 0, 1, 4, 4, "R3 NE");
    op(0, 15, 13, 0, 1, 7, 32'h8000_0000, 3, "R3 GEU");
    // R4 guard off (entry 2 is 0): both write 0
    op(2, 1, 3, 0, 1, 0, 1, 1, "R4 guard off");
    // R5 OR types
    op(0, 2, 4, 2, 3, 0, 1, 1, "R5 ON true OC no");
    op(0, 4, 8, 2, 3, 0, 1, 2, "R5 ON no OC true");
    op(1, 10, 14, 2, 3, 0, 1, 1, "R5 guard off");
    // R6 AND types
    op(0, 6, 7, 4, 5, 0, 1, 1, "R6 AN no AC clears");
    op(0, 9, 11, 4, 5, 0, 1, 2, "R6 AN clears AC no");
    op(1, 15, 12, 4, 5, 0, 1, 2, "R6 guard off");
    // R7 reserved codes
    op(0, 12, 13, 6, 7, 0, 1, 1, "R7 reserved");
    // R8 no issue
    idle("R8 idle");
    // R10 same destination
    op(0, 5, 5, 0, 1, 0, 1, 1, "R10 dst2 wins");
    op(0, 5, 5, 1, 0, 0, 1, 1, "R10 dst2 wins b");
    // R2 writes to entry 0
    op(0, 0, 0, 1, 4, 0, 1, 2, "R2 entry0");
    // R9 guard taken from old state
    op(5, 5, 6, 1, 0, 0, 1, 1, "R9 self guard");
    op(5, 6, 7, 0, 2, 0, 1, 1, "R9 new guard off");
    // R11 wired OR into 3 (preset 0) and wired AND into 4 (preset 1)
    op(0, 3, 4, 0, 1, 0, 1, 2, "R11 preset");
    op(0, 3, 3, 2, 2, 2, 5, 1, "R11 OR term0");
    op(0, 3, 3, 3, 3, 2, 5, 1, "R11 OR term1");
    op(0, 4, 4, 4, 4, 2, 1, 5, "R11 AND term0");
    op(0, 4, 4, 5, 5, 2, 5, 1, "R11 AND term1");
    idle("R8 final");
    repeat (3) @(posedge clk);
    #1 done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule